// File: doc/BRIEF.md
# Two-Level Logical-to-Physical Address Translator with Associative Cache

This block turns a 20-bit logical address into a 20-bit physical address. The logical address splits, from the top down, into a 4-bit segment number, an 8-bit page number and an 8-bit word offset. The physical address is a 12-bit block number placed above the same 8-bit offset. The block first looks in a small fully associative translation cache, keyed on segment and page. On a hit it answers in one cycle. On a miss it reads a segment descriptor and then a page-table entry from internal tables. If that walk ends without a fault, it writes the mapping into the cache, replacing entries in first-in first-out order.

Each segment descriptor holds a page-table base, a length in pages and an access-rights code. The page number is added to the base to index the page table. Every request states its kind (data read, data write or instruction fetch) and whether it comes from user or supervisor mode. The block reports a length fault, a protection fault or a page fault instead of an address when the request is not allowed. Software fills both tables through a single write port, and every table write empties the cache.

Top module: `segpage_xlate`

## Requirements
- R1: A fault-free response carries resp_addr = {block number, word offset}. The block number comes from the page-table entry, which is laid out as {valid at bit 12, block in bits 11:0}. The word offset is the low 8 bits of the logical address, whose layout is {segment[19:16], page[15:8], word[7:0]}.
- R2: A request accepted while idle (req_valid high and busy low) whose segment and page are held in the cache produces resp_valid exactly one cycle after the accepting edge.
- R3: A request that misses the cache raises busy for two cycles and produces resp_valid three cycles after the accepting edge, with busy already low.
- R4: The segment descriptor is laid out as {rights[20:19], length[18:10], page-table base[9:0]}. When the page number is greater than or equal to the length, the fault code is 2 (length). This check outranks every other fault.
- R5: When the page-table entry at index base + page has its valid bit clear, the fault code is 1 (page fault), provided that no length or protection fault applies.
- R6: Rights code 0 allows every access. Code 1 faults on writes. Code 2 faults on data reads and data writes. Code 3 faults on any access made with req_user high. A protection fault gives fault code 3, on a cache hit as well as on a walk. Access kinds are 0 read, 1 write, 2 fetch.
- R7: Any faulting response has resp_addr equal to zero and leaves the cache unchanged, so the same segment and page miss again. A fault-free response has fault code 0.
- R8: The cache holds 8 entries. It refills them in first-in first-out order, so the ninth distinct refill evicts the oldest entry and leaves the others in place.
- R9: Any table write (tw_en high) empties the cache, so later lookups walk the tables again and see the new contents.
- R10: During and right after reset, resp_valid and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request; taken when busy is low |
| req_laddr | input | 20 | Logical address {segment, page, word} |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | High for user-mode requests |
| busy | output | 1 | A table walk is in progress; requests are not taken |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_addr | output | 20 | Physical address {block, word}; zero on a fault |
| resp_fault | output | 2 | 0 none, 1 page, 2 length, 3 protection |
| tw_en | input | 1 | Table write strobe; also empties the cache |
| tw_sel | input | 1 | 0 selects the segment table, 1 selects the page table |
| tw_addr | input | 10 | Entry index (segment number in the low 4 bits) |
| tw_data | input | 21 | Descriptor, or page-table entry in the low 13 bits |

## Verification
The hardest state to reach from the ports is a full cache whose oldest entry is about to be replaced. Faulting walks do not refill the cache, so the only way to tell a replacement happened is by response latency. The stimulus first places four mappings through a table of mixed hit, miss and fault cases, then forces five more refills from fresh pages. It then probes by latency that the oldest mapping is gone while the newer ones still hit. A re-walk of the oldest mapping then pushes out the next-oldest one, which is shown the same way.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_LEN  = 2'd2,
        FLT_PROT = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        RGT_RW  = 2'd0,
        RGT_RO  = 2'd1,
        RGT_XO  = 2'd2,
        RGT_SYS = 2'd3
    } rights_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEG  = 2'd1,
        ST_PAGE = 2'd2
    } walk_state_e;

endpackage

// File: rtl/xlt_ram.sv
module xlt_ram #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/xlt_access.sv
module xlt_access
    import xlt_pkg::*;
(
    input  logic [1:0] rights,
    input  logic [1:0] acc,
    input  logic       user,
    output logic       violate
);
    always_comb begin
        unique case (rights)
            RGT_RW:  violate = 1'b0;
            RGT_RO:  violate = (acc == ACC_WRITE);
            RGT_XO:  violate = (acc != ACC_FETCH);
            default: violate = user;
        endcase
    end
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb #(
    parameter int N  = 8,
    parameter int KW = 12,
    parameter int VW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [KW-1:0] lkp_key,
    output logic          hit,
    output logic [VW-1:0] hit_data,
    input  logic          fill_en,
    input  logic [KW-1:0] fill_key,
    input  logic [VW-1:0] fill_data,
    output logic [N-1:0]  vld_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    typedef struct packed {
        logic [N-1:0]          vld;
        logic [N-1:0][KW-1:0]  key;
        logic [N-1:0][VW-1:0]  val;
        logic [PW-1:0]         ptr;
    } tlb_s;

    tlb_s st_d, st_q;
    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = st_q.vld[i] && (st_q.key[i] == lkp_key);
    end

    always_comb begin
        hit      = |match;
        hit_data = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit_data = hit_data | st_q.val[i];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld = '0;
        end else if (fill_en) begin
            st_d.vld[st_q.ptr] = 1'b1;
            st_d.key[st_q.ptr] = fill_key;
            st_d.val[st_q.ptr] = fill_data;
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.vld;
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
    import xlt_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8,
    parameter int WORD_W = 8,
    parameter int BLK_W  = 12,
    parameter int PT_AW  = 10,
    parameter int TLB_N  = 8,
    localparam int LA_W  = SEG_W + PAGE_W + WORD_W,
    localparam int PA_W  = BLK_W + WORD_W,
    localparam int LEN_W = PAGE_W + 1,
    localparam int SD_W  = 2 + LEN_W + PT_AW,
    localparam int PTE_W = 1 + BLK_W,
    localparam int TW_W  = (SD_W > PTE_W) ? SD_W : PTE_W,
    localparam int TW_AW = (SEG_W > PT_AW) ? SEG_W : PT_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LA_W-1:0]  req_laddr,
    input  logic [1:0]       req_acc,
    input  logic             req_user,
    output logic             busy,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_addr,
    output logic [1:0]       resp_fault,
    input  logic             tw_en,
    input  logic             tw_sel,
    input  logic [TW_AW-1:0] tw_addr,
    input  logic [TW_W-1:0]  tw_data
);
    localparam int KEY_W = SEG_W + PAGE_W;
    localparam int TV_W  = 2 + BLK_W;

    typedef struct packed {
        walk_state_e       st;
        logic [LA_W-1:0]   la;
        logic [1:0]        acc;
        logic              user;
        logic [SD_W-1:0]   sd;
        logic              rv;
        logic [PA_W-1:0]   ra;
        logic [1:0]        rf;
    } ctl_s;

    ctl_s st_d, st_q;

    // Fields of the held request
    logic [SEG_W-1:0]  q_seg;
    logic [PAGE_W-1:0] q_page;
    logic [WORD_W-1:0] q_word;
    assign q_seg  = st_q.la[LA_W-1 -: SEG_W];
    assign q_page = st_q.la[WORD_W +: PAGE_W];
    assign q_word = st_q.la[WORD_W-1:0];

    // Fields of the held segment descriptor
    logic [1:0]       sd_rights;
    logic [LEN_W-1:0] sd_len;
    logic [PT_AW-1:0] sd_base;
    assign sd_rights = st_q.sd[SD_W-1 -: 2];
    assign sd_len    = st_q.sd[PT_AW +: LEN_W];
    assign sd_base   = st_q.sd[PT_AW-1:0];

    // Segment table
    logic [SD_W-1:0] seg_rdata;
    xlt_ram #(.AW(SEG_W), .DW(SD_W)) i_segtab (
        .clk   (clk),
        .we    (tw_en && !tw_sel),
        .waddr (tw_addr[SEG_W-1:0]),
        .wdata (tw_data[SD_W-1:0]),
        .raddr (q_seg),
        .rdata (seg_rdata)
    );

    // Page table
    logic [PT_AW-1:0] pt_idx;
    logic [PTE_W-1:0] pt_rdata;
    assign pt_idx = sd_base + PT_AW'(q_page);

    xlt_ram #(.AW(PT_AW), .DW(PTE_W)) i_pagetab (
        .clk   (clk),
        .we    (tw_en && tw_sel),
        .waddr (tw_addr[PT_AW-1:0]),
        .wdata (tw_data[PTE_W-1:0]),
        .raddr (pt_idx),
        .rdata (pt_rdata)
    );

    logic unused_tw_hi;
    assign unused_tw_hi = ^tw_data;

    logic             pte_ok;
    logic [BLK_W-1:0] pte_blk;
    assign pte_ok  = pt_rdata[BLK_W];
    assign pte_blk = pt_rdata[BLK_W-1:0];

    // Translation cache
    logic             tlb_hit;
    logic [TV_W-1:0]  tlb_data;
    logic             tlb_fill;
    logic [TLB_N-1:0] tlb_vld;

    xlt_tlb #(.N(TLB_N), .KW(KEY_W), .VW(TV_W)) i_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tw_en),
        .lkp_key   (req_laddr[LA_W-1:WORD_W]),
        .hit       (tlb_hit),
        .hit_data  (tlb_data),
        .fill_en   (tlb_fill),
        .fill_key  (st_q.la[LA_W-1:WORD_W]),
        .fill_data ({sd_rights, pte_blk}),
        .vld_o     (tlb_vld)
    );

    // Rights checks: one on the hit path, one on the walk path
    logic vio_hit, vio_walk;

    xlt_access i_acc_hit (
        .rights  (tlb_data[TV_W-1 -: 2]),
        .acc     (req_acc),
        .user    (req_user),
        .violate (vio_hit)
    );

    xlt_access i_acc_walk (
        .rights  (sd_rights),
        .acc     (st_q.acc),
        .user    (st_q.user),
        .violate (vio_walk)
    );

    logic len_bad;
    assign len_bad = ({1'b0, q_page} >= sd_len);

    always_comb begin
        st_d     = st_q;
        st_d.rv  = 1'b0;
        tlb_fill = 1'b0;
        unique case (st_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.la   = req_laddr;
                    st_d.acc  = req_acc;
                    st_d.user = req_user;
                    if (tlb_hit) begin
                        st_d.rv = 1'b1;
                        if (vio_hit) begin
                            st_d.rf = FLT_PROT;
                            st_d.ra = '0;
                        end else begin
                            st_d.rf = FLT_NONE;
                            st_d.ra = {tlb_data[BLK_W-1:0], req_laddr[WORD_W-1:0]};
                        end
                    end else begin
                        st_d.st = ST_SEG;
                    end
                end
            end
            ST_SEG: begin
                st_d.sd = seg_rdata;
                st_d.st = ST_PAGE;
            end
            ST_PAGE: begin
                st_d.st = ST_IDLE;
                st_d.rv = 1'b1;
                st_d.ra = '0;
                if (len_bad) begin
                    st_d.rf = FLT_LEN;
                end else if (vio_walk) begin
                    st_d.rf = FLT_PROT;
                end else if (!pte_ok) begin
                    st_d.rf = FLT_PAGE;
                end else begin
                    st_d.rf  = FLT_NONE;
                    st_d.ra  = {pte_blk, q_word};
                    tlb_fill = 1'b1;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = (st_q.st != ST_IDLE);
    assign resp_valid = st_q.rv;
    assign resp_addr  = st_q.ra;
    assign resp_fault = st_q.rf;
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker #(
    parameter int N    = 8,
    parameter int PA_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            resp_valid,
    input logic [PA_W-1:0] resp_addr,
    input logic [1:0]      resp_fault,
    input logic            tw_en,
    input logic [N-1:0]    tlb_vld
);
    // R2 / R3: an accepted request either answers next cycle or starts a walk
    a_r2_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (resp_valid ^ busy));

    // R3: the response never coincides with the walk in progress
    a_r3_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !busy);

    // R3: a walk ends with a response
    a_r3_walk_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> resp_valid);

    // R7: faulting responses carry no address
    a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 2'd0) |-> (resp_addr == '0));

    // R8: at most one cache entry becomes valid per cycle
    a_r8_one_fill: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(tlb_vld) <= $countones($past(tlb_vld)) + 1));

    // R9: a table write leaves the cache empty
    a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tw_en |=> (tlb_vld == '0));
endmodule

bind segpage_xlate xlt_checker #(.N(TLB_N), .PA_W(PA_W)) i_xlt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .resp_valid (resp_valid),
    .resp_addr  (resp_addr),
    .resp_fault (resp_fault),
    .tw_en      (tw_en),
    .tlb_vld    (tlb_vld)
);

// File: tb/test_segpage_xlate.sv
`timescale 1ns/1ps
module test_segpage_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_laddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        busy, resp_valid;
    logic [19:0] resp_addr;
    logic [1:0]  resp_fault;
    logic        tw_en = 1'b0;
    logic        tw_sel = 1'b0;
    logic [9:0]  tw_addr = '0;
    logic [20:0] tw_data = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    segpage_xlate i_segpage_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
        .req_acc(req_acc), .req_user(req_user), .busy(busy),
        .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_fault(resp_fault),
        .tw_en(tw_en), .tw_sel(tw_sel), .tw_addr(tw_addr), .tw_data(tw_data)
    );

    // {seg, page, word, acc, user, fault, addr, latency}
    localparam int NV = 17;
    localparam logic [46:0] VEC [NV] = '{
        {4'd0, 8'd1,  8'h55, 2'd0, 1'b1, 2'd0, 20'h10155, 2'd3},
        {4'd0, 8'd1,  8'hAA, 2'd1, 1'b1, 2'd0, 20'h101AA, 2'd1},
        {4'd0, 8'd3,  8'h00, 2'd0, 1'b1, 2'd1, 20'h00000, 2'd3},
        {4'd0, 8'd16, 8'h00, 2'd0, 1'b1, 2'd2, 20'h00000, 2'd3},
        {4'd1, 8'd2,  8'h00, 2'd1, 1'b1, 2'd3, 20'h00000, 2'd3},
        {4'd1, 8'd2,  8'h12, 2'd0, 1'b1, 2'd0, 20'h20212, 2'd3},
        {4'd1, 8'd2,  8'h00, 2'd1, 1'b1, 2'd3, 20'h00000, 2'd1},
        {4'd1, 8'd2,  8'h34, 2'd2, 1'b1, 2'd0, 20'h20234, 2'd1},
        {4'd2, 8'd0,  8'h77, 2'd2, 1'b1, 2'd0, 20'h30077, 2'd3},
        {4'd2, 8'd0,  8'h00, 2'd0, 1'b1, 2'd3, 20'h00000, 2'd1},
        {4'd3, 8'd1,  8'h00, 2'd0, 1'b1, 2'd3, 20'h00000, 2'd3},
        {4'd3, 8'd1,  8'h9C, 2'd0, 1'b0, 2'd0, 20'h4019C, 2'd3},
        {4'd3, 8'd1,  8'h00, 2'd0, 1'b1, 2'd3, 20'h00000, 2'd1},
        {4'd5, 8'd0,  8'h00, 2'd0, 1'b0, 2'd2, 20'h00000, 2'd3},
        {4'd1, 8'd5,  8'h00, 2'd1, 1'b1, 2'd2, 20'h00000, 2'd3},
        {4'd2, 8'd3,  8'h00, 2'd0, 1'b1, 2'd3, 20'h00000, 2'd3},
        {4'd2, 8'd3,  8'h00, 2'd2, 1'b1, 2'd1, 20'h00000, 2'd3}
    };

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic twrite(input bit sel, input int addr, input logic [20:0] data);
        @(negedge clk);
        tw_en = 1'b1; tw_sel = sel; tw_addr = 10'(addr); tw_data = data;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    task automatic seg_desc(input int seg, input logic [1:0] rgt, input int len, input int base);
        twrite(1'b0, seg, {rgt, 9'(len), 10'(base)});
    endtask

    task automatic pte(input int idx, input bit v, input int blk);
        twrite(1'b1, idx, {8'd0, v, 12'(blk)});
    endtask

    task automatic xlate(input int seg, input int page, input int word, input int acc,
                         input bit user, input int efault, input int eaddr, input int elat);
        int lat;
        @(negedge clk);
        req_laddr = {4'(seg), 8'(page), 8'(word)};
        req_acc = 2'(acc); req_user = user; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        check(lat == elat, $sformatf("R2 R3 latency seg%0d page%0d", seg, page), lat, elat);
        check(resp_fault == 2'(efault), $sformatf("R4 R5 R6 fault code seg%0d page%0d", seg, page),
              int'(resp_fault), efault);
        check(resp_addr == 20'(eaddr), $sformatf("R1 R7 address seg%0d page%0d", seg, page),
              int'(resp_addr), eaddr);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(resp_valid == 1'b0, "R10 resp_valid in reset", int'(resp_valid), 0);
        check(busy == 1'b0, "R10 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(resp_valid == 1'b0 && busy == 1'b0, "R10 idle after reset",
              int'({resp_valid, busy}), 0);

        // Table contents
        seg_desc(0, 2'd0, 16, 0);
        seg_desc(1, 2'd1, 4, 100);
        seg_desc(2, 2'd2, 4, 200);
        seg_desc(3, 2'd3, 4, 300);
        seg_desc(5, 2'd0, 0, 0);
        for (int i = 0; i < 16; i++) pte(i, i != 3, 12'h100 + i);
        for (int i = 0; i < 4; i++) begin
            pte(100 + i, 1'b1, 12'h200 + i);
            pte(200 + i, i != 3, 12'h300 + i);
            pte(300 + i, 1'b1, 12'h400 + i);
        end

        for (int v = 0; v < NV; v++) begin
            xlate(int'(VEC[v][46:43]), int'(VEC[v][42:35]), int'(VEC[v][34:27]),
                  int'(VEC[v][26:25]), VEC[v][24], int'(VEC[v][23:22]),
                  int'(VEC[v][21:2]), int'(VEC[v][1:0]));
        end

        // R3: busy is high during a walk
        @(negedge clk);
        req_laddr = {4'd0, 8'd9, 8'h01}; req_acc = 2'd0; req_user = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R3 busy during walk", int'(busy), 1);
        @(negedge clk);
        check(busy == 1'b1 && !resp_valid, "R3 busy second walk cycle", int'({busy, resp_valid}), 2);
        @(negedge clk);
        check(busy == 1'b0 && resp_valid, "R3 response after walk", int'({busy, resp_valid}), 1);

        // R8: cache holds seg0p1, seg1p2, seg2p0, seg3p1, seg0p9; four more fills wrap
        for (int p = 4; p < 8; p++) xlate(0, p, 0, 0, 1'b1, 0, (12'h100 + p) << 8, 3);
        xlate(2, 0, 0, 2, 1'b1, 0, 20'h30000, 1);   // R8 newer entry kept
        xlate(0, 1, 0, 0, 1'b1, 0, 20'h10100, 3);   // R8 oldest evicted
        xlate(3, 1, 0, 0, 1'b0, 0, 20'h40100, 1);   // R8 still held
        xlate(1, 2, 0, 2, 1'b1, 0, 20'h20200, 3);   // R8 next-oldest evicted

        // R9: table write empties cache and new contents are seen
        xlate(0, 4, 7, 0, 1'b1, 0, 20'h10407, 1);
        pte(4, 1'b1, 12'h7AB);
        xlate(0, 4, 7, 0, 1'b1, 0, 20'h7AB07, 3);
        xlate(2, 0, 0, 2, 1'b1, 0, 20'h30000, 3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule